// File: doc/BRIEF.md
# Write-Once Flash Page Buffer

This block holds one page of instruction words while software assembles them ahead of a flash page commit. A load port writes one word per cycle into a slot chosen by index. Each slot carries a filled flag, and a slot that is already filled refuses any further load until the whole buffer is erased. A refused load leaves the stored word untouched and raises a one-cycle error pulse.

The buffer erases itself on four events:
- the end of a page commit;
- a read-while-write re-enable command;
- reset;
- an EEPROM write that arrives while at least one word is loaded.

An erase sets every word to all-ones, which is the erased-flash value, and drops every filled flag. During the commit phase the flash-array side reads the page back through a registered port, one word per cycle, selected by index. Command timing and the flash array itself live outside this block.

Top module: `wob_page_buffer`

## Requirements
- R1: After reset every slot reads back as all-ones with its filled flag at 0, and `dup_err` is 0.
- R2: A load to an unfilled slot stores `ld_data` at the edge where `ld_valid` is sampled high and sets that slot's filled flag.
- R3: A load to a filled slot leaves the stored word and all flags unchanged, and `dup_err` is 1 for exactly the cycle after that load was sampled.
- R4: A `commit_done` pulse erases the buffer: all words become all-ones and all flags 0, and any slot may then be loaded again.
- R5: An `rww_reenable` pulse erases the buffer in the same way as R4.
- R6: An `eeprom_wr` pulse while at least one slot is filled erases the buffer in the same way as R4.
- R7: When an erase event and a load are sampled in the same cycle, the erase wins: the load is discarded and `dup_err` stays 0.
- R8: With `rd_en` high at an edge, `rd_data` and `rd_filled` show the word and flag of slot `rd_idx` from the next cycle on. With `rd_en` low they hold their value.
- R9: A load changes only the slot it addresses. Every other slot keeps its word and its flag.
- R10: All `PAGE_WORDS` slots can be filled, each with its own value, and each can be read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release must already be synchronous to clk |
| ld_valid | input | 1 | Load strobe |
| ld_idx | input | IDX_W | Slot index of the load |
| ld_data | input | WORD_W | Word to load |
| commit_done | input | 1 | One-cycle pulse marking the end of a page commit |
| rww_reenable | input | 1 | One-cycle pulse for the read-while-write re-enable command |
| eeprom_wr | input | 1 | One-cycle pulse marking an EEPROM write |
| rd_en | input | 1 | Readout clock enable |
| rd_idx | input | IDX_W | Slot index to read |
| rd_data | output | WORD_W | Registered word of the selected slot |
| rd_filled | output | 1 | Registered filled flag of the selected slot |
| dup_err | output | 1 | One-cycle pulse after a refused duplicate load |

## Verification
The hardest case to reach from the ports is an erase event and a load that collide in the same cycle while the addressed slot is already filled. If the design gets this wrong, the duplicate error can fire and a stale word can survive. The bench fills a slot first and then raises the load and the erase strobe together. Afterwards it reads the slot back and checks that it is erased, that no error pulse appeared, and that a fresh load to the slot is accepted. The EEPROM case is also driven twice, once on an empty buffer and once on a partly loaded one, so that the erase is seen to depend on loading being in progress.

// File: rtl/wob_pkg.sv
package wob_pkg;
  // Erase request sources, gathered from the block's inputs
  typedef struct packed {
    logic commit;
    logic reenable;
    logic eeprom;
  } wob_clr_src_t;
endpackage

// File: rtl/wob_clear_ctrl.sv
module wob_clear_ctrl
  import wob_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  wob_clr_src_t src_i,
  input  logic         any_filled_i,
  output logic         clr_o
);
  // EEPROM write only discards data while a page load is under way
  logic eeprom_hit;
  assign eeprom_hit = src_i.eeprom & any_filled_i;
  assign clr_o      = src_i.commit | src_i.reenable | eeprom_hit;

  // R6: an EEPROM write that arrives with nothing loaded triggers no erase
  a_r6_eeprom_idle_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i.eeprom && !any_filled_i && !src_i.commit && !src_i.reenable) |-> !clr_o);
endmodule

// File: rtl/wob_store.sv
module wob_store #(
  parameter int WORD_W     = 16,
  parameter int PAGE_WORDS = 32,
  localparam int IDX_W     = $clog2(PAGE_WORDS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ld_valid_i,
  input  logic [IDX_W-1:0]                   ld_idx_i,
  input  logic [WORD_W-1:0]                  ld_data_i,
  input  logic                               clr_i,
  output logic [PAGE_WORDS-1:0][WORD_W-1:0]  words_o,
  output logic [PAGE_WORDS-1:0]              filled_o,
  output logic                               any_filled_o,
  output logic                               dup_err_o
);
  localparam logic [WORD_W-1:0] ERASED = '1;

  logic [PAGE_WORDS-1:0][WORD_W-1:0] data_q, data_d;
  logic [PAGE_WORDS-1:0]             vld_q, vld_d;
  logic [PAGE_WORDS-1:0]             wr_hit;
  logic                              dup_d, dup_q;

  genvar gi;
  generate
    for (gi = 0; gi < PAGE_WORDS; gi++) begin : g_slot
      // Accept only into an empty slot, and never in an erase cycle
      assign wr_hit[gi] = ld_valid_i && !clr_i && !vld_q[gi]
                          && (ld_idx_i == IDX_W'(gi));

      always_comb begin
        data_d[gi] = data_q[gi];
        vld_d[gi]  = vld_q[gi];
        if (clr_i) begin
          data_d[gi] = ERASED;
          vld_d[gi]  = 1'b0;
        end else if (wr_hit[gi]) begin
          data_d[gi] = ld_data_i;
          vld_d[gi]  = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[gi] <= ERASED;
          vld_q[gi]  <= 1'b0;
        end else if (clr_i || wr_hit[gi]) begin
          data_q[gi] <= data_d[gi];
          vld_q[gi]  <= vld_d[gi];
        end
      end
    end
  endgenerate

  assign dup_d = ld_valid_i && !clr_i && vld_q[ld_idx_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dup_q <= 1'b0;
    else        dup_q <= dup_d;
  end

  assign words_o      = data_q;
  assign filled_o     = vld_q;
  assign any_filled_o = |vld_q;
  assign dup_err_o    = dup_q;

  // R3: a refused load leaves the addressed word as it was
  a_r3_dup_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && !clr_i && vld_q[ld_idx_i]) |=>
      (data_q[$past(ld_idx_i)] == $past(data_q[ld_idx_i])));
  // R4: any erase leaves the bitmap empty
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (vld_q == '0));
  // R9: without an erase, filled flags never fall
  a_r9_flags_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((vld_q & $past(vld_q)) == $past(vld_q)));
  // R9: at most one slot changes per cycle outside an erase
  a_r9_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ($countones(vld_q ^ $past(vld_q)) <= 1));
  // R7: an erase cycle never reports a duplicate
  a_r7_no_err_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !dup_q);
endmodule

// File: rtl/wob_readout.sv
module wob_readout #(
  parameter int WORD_W     = 16,
  parameter int PAGE_WORDS = 32,
  localparam int IDX_W     = $clog2(PAGE_WORDS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd_en_i,
  input  logic [IDX_W-1:0]                   rd_idx_i,
  input  logic [PAGE_WORDS-1:0][WORD_W-1:0]  words_i,
  input  logic [PAGE_WORDS-1:0]              filled_i,
  output logic [WORD_W-1:0]                  rd_data_o,
  output logic                               rd_filled_o
);
  logic [WORD_W-1:0] sel_word;
  logic              sel_flag;
  logic [WORD_W-1:0] data_q;
  logic              flag_q;

  always_comb begin
    sel_word = words_i[rd_idx_i];
    sel_flag = filled_i[rd_idx_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '1;
      flag_q <= 1'b0;
    end else if (rd_en_i) begin
      data_q <= sel_word;
      flag_q <= sel_flag;
    end
  end

  assign rd_data_o   = data_q;
  assign rd_filled_o = flag_q;

  // R8: the output register holds while the enable is low
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> ($stable(rd_data_o) && $stable(rd_filled_o)));
  // R8: an unfilled slot always reads back erased
  a_r8_unfilled_is_erased: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !filled_i[rd_idx_i]) |=> (rd_data_o == '1));
endmodule

// File: rtl/wob_page_buffer.sv
module wob_page_buffer
  import wob_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int PAGE_WORDS = 32,
  localparam int IDX_W     = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              commit_done,
  input  logic              rww_reenable,
  input  logic              eeprom_wr,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_filled,
  output logic              dup_err
);
  wob_clr_src_t                      src;
  logic                              clr;
  logic                              any_filled;
  logic [PAGE_WORDS-1:0][WORD_W-1:0] words;
  logic [PAGE_WORDS-1:0]             filled;

  assign src = '{commit: commit_done, reenable: rww_reenable, eeprom: eeprom_wr};

  wob_clear_ctrl u_clr (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (src),
    .any_filled_i (any_filled),
    .clr_o        (clr)
  );

  wob_store #(.WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_valid_i   (ld_valid),
    .ld_idx_i     (ld_idx),
    .ld_data_i    (ld_data),
    .clr_i        (clr),
    .words_o      (words),
    .filled_o     (filled),
    .any_filled_o (any_filled),
    .dup_err_o    (dup_err)
  );

  wob_readout #(.WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_i     (rd_en),
    .rd_idx_i    (rd_idx),
    .words_i     (words),
    .filled_i    (filled),
    .rd_data_o   (rd_data),
    .rd_filled_o (rd_filled)
  );

  // R3: an error pulse only follows a sampled load
  a_r3_err_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> $past(ld_valid));
  // R5: the re-enable command leaves every slot unfilled
  a_r5_reenable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rww_reenable |=> (filled == '0));
endmodule

// File: tb/test_wob_page_buffer.sv
module test_wob_page_buffer;
  localparam int WORD_W     = 16;
  localparam int PAGE_WORDS = 32;
  localparam int IDX_W      = $clog2(PAGE_WORDS);
  localparam logic [WORD_W-1:0] ONES = '1;

  logic              clk;
  logic              rst_n;
  logic              ld_valid;
  logic [IDX_W-1:0]  ld_idx;
  logic [WORD_W-1:0] ld_data;
  logic              commit_done;
  logic              rww_reenable;
  logic              eeprom_wr;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_data;
  logic              rd_filled;
  logic              dup_err;

  int checks;
  int failures;

  wob_page_buffer #(.WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS)) i_wob_page_buffer (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
    .commit_done(commit_done), .rww_reenable(rww_reenable), .eeprom_wr(eeprom_wr),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_filled(rd_filled),
    .dup_err(dup_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One-cycle load, with an optional erase strobe raised alongside it
  task automatic load(input int idx, input logic [WORD_W-1:0] d,
                      input logic with_commit = 1'b0);
    ld_valid    = 1'b1;
    ld_idx      = IDX_W'(idx);
    ld_data     = d;
    commit_done = with_commit;
    @(negedge clk);
    ld_valid    = 1'b0;
    commit_done = 1'b0;
  endtask

  task automatic read(input int idx, output logic [WORD_W-1:0] d, output logic f);
    rd_en  = 1'b1;
    rd_idx = IDX_W'(idx);
    @(negedge clk);
    rd_en  = 1'b0;
    d = rd_data;
    f = rd_filled;
  endtask

  task automatic expect_slot(input string req, input int idx,
                             input logic [WORD_W-1:0] d, input logic f);
    logic [WORD_W-1:0] rdd;
    logic rf;
    read(idx, rdd, rf);
    chk(req, rdd, d);
    chk(req, rf, f);
  endtask

  task automatic t_reset;
    chk("R1 dup_err", dup_err, 0);
    expect_slot("R1 slot0", 0, ONES, 1'b0);
    expect_slot("R1 slotN", PAGE_WORDS - 1, ONES, 1'b0);
  endtask

  task automatic t_load_and_dup;
    load(3, 16'h1234);
    chk("R2 no err on first load", dup_err, 0);
    expect_slot("R2 stored", 3, 16'h1234, 1'b1);
    load(3, 16'hBEEF);
    chk("R3 err pulse", dup_err, 1);
    @(negedge clk);
    chk("R3 err one cycle", dup_err, 0);
    expect_slot("R3 word unchanged", 3, 16'h1234, 1'b1);
    expect_slot("R9 neighbour", 4, ONES, 1'b0);
    expect_slot("R9 neighbour low", 2, ONES, 1'b0);
  endtask

  task automatic t_commit;
    commit_done = 1'b1;
    @(negedge clk);
    commit_done = 1'b0;
    expect_slot("R4 erased", 3, ONES, 1'b0);
    load(3, 16'h0F0F);
    chk("R4 reload accepted", dup_err, 0);
    expect_slot("R4 reload", 3, 16'h0F0F, 1'b1);
  endtask

  task automatic t_reenable;
    rww_reenable = 1'b1;
    @(negedge clk);
    rww_reenable = 1'b0;
    expect_slot("R5 erased", 3, ONES, 1'b0);
  endtask

  task automatic t_eeprom;
    eeprom_wr = 1'b1;
    @(negedge clk);
    eeprom_wr = 1'b0;
    load(7, 16'hA5A5);
    chk("R6 idle eeprom no dup", dup_err, 0);
    expect_slot("R6 load after idle eeprom", 7, 16'hA5A5, 1'b1);
    load(8, 16'h5A5A);
    eeprom_wr = 1'b1;
    @(negedge clk);
    eeprom_wr = 1'b0;
    expect_slot("R6 erased slot7", 7, ONES, 1'b0);
    expect_slot("R6 erased slot8", 8, ONES, 1'b0);
  endtask

  task automatic t_collide;
    load(5, 16'h1111);
    load(5, 16'h2222, 1'b1);
    chk("R7 no err on collision", dup_err, 0);
    expect_slot("R7 erase wins", 5, ONES, 1'b0);
    load(6, 16'h3333, 1'b1);
    expect_slot("R7 load to empty dropped", 6, ONES, 1'b0);
    load(5, 16'h4444);
    chk("R7 reload no err", dup_err, 0);
    expect_slot("R7 reload", 5, 16'h4444, 1'b1);
  endtask

  task automatic t_hold;
    logic [WORD_W-1:0] d0;
    logic f0;
    read(5, d0, f0);
    rd_idx = IDX_W'(0);
    @(negedge clk);
    @(negedge clk);
    chk("R8 hold data", rd_data, 16'h4444);
    chk("R8 hold flag", rd_filled, 1);
  endtask

  task automatic t_full;
    commit_done = 1'b1;
    @(negedge clk);
    commit_done = 1'b0;
    for (int i = 0; i < PAGE_WORDS; i++) load(i, WORD_W'(16'hC000 + i * 3));
    for (int i = 0; i < PAGE_WORDS; i++)
      expect_slot("R10 full page", i, WORD_W'(16'hC000 + i * 3), 1'b1);
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; ld_valid = 0; ld_idx = '0; ld_data = '0;
    commit_done = 0; rww_reenable = 0; eeprom_wr = 0; rd_en = 0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and_dup();
    t_commit();
    t_reenable();
    t_eeprom();
    t_collide();
    t_hold();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule